// File: doc/BRIEF.md
# Multi-mode 8/16-bit timer counter

This block is a timer/counter that counts either as one 8-bit counter in the low byte or as a single 16-bit counter. Three mode bits choose between free-running counting, clearing on a compare value, and input capture of the running count on a rising edge of an external pin. Counting is paced by a tick from a small clock-select stage. That stage is a free-running divide-by-1, divide-by-8 or divide-by-64 prescaler, and it can also stop the count altogether.

A processor drives the block through write strobes. These load the counter, load the compare register, load a control byte that holds the mode, clock select and interrupt enables, and clear flags by writing ones. The block sets three sticky flags: overflow, compare match and capture. The interrupt request is the OR of the flags whose enables are set, and an interrupt acknowledge also clears the overflow flag.

Top module: `multimode_timer`

## Requirements
- R1: After reset the count, the capture register, all three flags and the interrupt request are zero, and the control byte is zero, so the clock select is stopped and the mode is normal 8-bit.
- R2: Clock select is control bits [4:3]. Value 0 gives no ticks, and the count holds unless the processor writes it. Value 1 gives a tick every clock. Value 2 gives one tick in every 8 clocks and value 3 one tick in every 64 clocks, both taken from a prescaler that runs freely from reset.
- R3: In normal 8-bit mode each tick adds one to the low byte, which goes from 0xFF to 0x00, and the high byte keeps its value.
- R4: In 8-bit clear-on-compare mode, a tick that finds the low byte equal to compare bits [7:0] sets the low byte to zero; any other tick adds one.
- R5: In both 16-bit modes each tick adds one to the full 16-bit count, which goes from 0xFFFF to 0x0000.
- R6: The overflow flag (flag bit 0) is set by a tick that leaves a low byte of 0xFF in 8-bit modes, or a count of 0xFFFF in 16-bit modes. Counting never clears it.
- R7: The overflow flag is cleared by a flag-clear write with bit 0 set, or by irq_ack. When a set and a clear fall in the same cycle, the flag ends up set.
- R8: The compare flag (flag bit 1) is set by a tick that finds the count equal to the compare register: only the low byte against compare bits [7:0] in 8-bit modes, all 16 bits in 16-bit modes. Flag-clear bit 1 clears it, and a set in the same cycle wins.
- R9: A counter write loads its data on the next edge in place of any count or clear, and no overflow or compare event is raised in that cycle.
- R10: A compare write takes effect at the next edge in every mode, without a shadow copy.
- R11: In the capture modes, a rising edge on cap_in passes through a two-flop synchronizer. It is then detected on the third clock edge after the input changes, and that edge copies the count held before it into cap_val and sets the capture flag (flag bit 2, cleared by flag-clear bit 2). In the other modes cap_in changes neither cap_val nor the capture flag.
- R12: irq is high exactly when some flag is set whose enable is set: control bit 5 enables overflow, bit 6 compare and bit 7 capture.
- R13: Control bits [2:0] are {capture-enable, wide, clear-on-compare}. 000 selects normal 8-bit, 001 8-bit clear-on-compare, 01x 16-bit, 10x 8-bit capture and 11x 16-bit capture. The clear-on-compare bit is ignored whenever wide or capture-enable is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cap_in | input | 1 | Asynchronous capture input |
| cpu_cnt_we | input | 1 | Counter write strobe |
| cpu_cnt_wdata | input | 16 | Counter write data |
| cpu_cmp_we | input | 1 | Compare register write strobe |
| cpu_cmp_wdata | input | 16 | Compare register write data |
| cpu_ctrl_we | input | 1 | Control byte write strobe |
| cpu_ctrl_wdata | input | 8 | Control byte: mode [2:0], clock select [4:3], enables [7:5] |
| cpu_flag_clr | input | 3 | Write-one-to-clear: bit 0 overflow, 1 compare, 2 capture |
| irq_ack | input | 1 | Interrupt acknowledge, clears overflow flag |
| count | output | 16 | Current count |
| ovf_flag | output | 1 | Overflow flag |
| cmp_flag | output | 1 | Compare match flag |
| cap_val | output | 16 | Captured count |
| cap_flag | output | 1 | Capture flag |
| irq | output | 1 | Interrupt request |

## Verification
Directed sequences come first. The low byte is walked across 0xFF in normal mode and the full count across 0xFFFF in wide mode, which tells the 8-bit wrap from the 16-bit carry. Clear-on-compare runs with a small compare value, which separates the clear from a plain wrap, and a mode byte with both wide and clear-on-compare set shows that the clear is ignored. Counter writes are timed to land on a compare hit and flag clears to land on an overflow, which exposes the priority and set-wins rules. Windows of 64 and 128 clocks at the slow clock selects pin down the division ratios whatever the prescaler phase. Constrained random runs then mix mode changes, counter and compare writes, clears, acknowledges and capture-pin toggles, all checked each cycle against a model kept in the bench.

// File: rtl/tmr_pkg.sv
// Package: shared mode type, control byte layout and mode decode for the timer.
// Assumes an 8-bit control byte with the field positions given below.
package tmr_pkg;

    localparam int CTRL_W      = 8;
    localparam int CB_CTC      = 0;
    localparam int CB_WIDE     = 1;
    localparam int CB_CAPEN    = 2;
    localparam int CB_SEL_LO   = 3;
    localparam int CB_IEN_LO   = 5;
    localparam int NUM_FLAGS   = 3;

    typedef enum logic [2:0] {
        MD_NORM8  = 3'd0,
        MD_CTC8   = 3'd1,
        MD_WIDE16 = 3'd2,
        MD_CAP8   = 3'd3,
        MD_CAP16  = 3'd4
    } tmr_mode_e;

    // Map the three mode bits to an operating mode; capture-enable outranks width, width outranks clear-on-compare.
    function automatic tmr_mode_e decode_mode(input logic cap_en, input logic wide, input logic ctc);
        if (cap_en)
            return wide ? MD_CAP16 : MD_CAP8;
        else if (wide)
            return MD_WIDE16;
        else if (ctc)
            return MD_CTC8;
        else
            return MD_NORM8;
    endfunction

endpackage

// File: rtl/tmr_prescale.sv
// Module: free-running prescaler that turns a clock-select code into a one-cycle tick.
// Assumes select 0 = stopped, 1 = every clock, 2 = every 2**MID_LOG2 clocks,
// 3 = every 2**SLOW_LOG2 clocks. The divider runs from reset whatever the select.
module tmr_prescale #(
    parameter int MID_LOG2  = 3,
    parameter int SLOW_LOG2 = 6
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] sel,
    output logic       tick
);

    logic [SLOW_LOG2-1:0] div_q;

    // Free-running divider count.
    always_ff @(posedge clk) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_q + SLOW_LOG2'(1);
    end

    // Pick the tick source for the current select code.
    always_comb begin
        unique case (sel)
            2'd0:    tick = 1'b0;
            2'd1:    tick = 1'b1;
            2'd2:    tick = &div_q[MID_LOG2-1:0];
            default: tick = &div_q;
        endcase
    end

endmodule

// File: rtl/tmr_count_core.sv
// Module: counter register with width, clear-on-compare and processor load.
// Assumes tick is a one-cycle enable. A load outranks counting and suppresses
// the overflow and compare events of that cycle. In 8-bit modes the high byte is held.
module tmr_count_core
    import tmr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  tmr_mode_e        mode,
    input  logic [CNT_W-1:0] cmp_val,
    input  logic             ld_en,
    input  logic [CNT_W-1:0] ld_val,
    output logic [CNT_W-1:0] count,
    output logic             ev_ovf,
    output logic             ev_cmp
);

    localparam int HALF_W = CNT_W / 2;

    logic             wide;
    logic             ctc;
    logic             hit;
    logic             at_max;
    logic [HALF_W-1:0] lo_q;
    logic [HALF_W-1:0] hi_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_d;

    assign lo_q = cnt_q[HALF_W-1:0];
    assign hi_q = cnt_q[CNT_W-1:HALF_W];

    // Mode-dependent width, compare hit and maximum detection.
    always_comb begin
        wide   = (mode == MD_WIDE16) || (mode == MD_CAP16);
        ctc    = (mode == MD_CTC8);
        hit    = wide ? (cnt_q == cmp_val) : (lo_q == cmp_val[HALF_W-1:0]);
        at_max = wide ? (&cnt_q) : (&lo_q);
    end

    // Events are raised only by a tick that is not overridden by a load.
    assign ev_ovf = tick && !ld_en && at_max;
    assign ev_cmp = tick && !ld_en && hit;

    // Next count: load, then tick-driven clear or increment.
    always_comb begin
        cnt_d = cnt_q;
        if (ld_en)
            cnt_d = ld_val;
        else if (tick) begin
            if (wide)
                cnt_d = cnt_q + CNT_W'(1);
            else if (ctc && hit)
                cnt_d = {hi_q, {HALF_W{1'b0}}};
            else
                cnt_d = {hi_q, lo_q + HALF_W'(1)};
        end
    end

    // Counter register.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign count = cnt_q;

endmodule

// File: rtl/tmr_capture.sv
// Module: capture pin synchronizer, rising-edge detector and capture register.
// Assumes cap_in is asynchronous; SYNC_STAGES flops precede the edge detector.
module tmr_capture #(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cap_in,
    input  logic             enable,
    input  logic [CNT_W-1:0] count,
    output logic [CNT_W-1:0] cap_val,
    output logic             cap_event
);

    logic [SYNC_STAGES:0] shift_q;
    logic [CNT_W-1:0]     cap_q;

    // Synchronizer chain plus one delay flop for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) shift_q <= '0;
        else        shift_q <= {shift_q[SYNC_STAGES-1:0], cap_in};
    end

    assign cap_event = enable && shift_q[SYNC_STAGES-1] && !shift_q[SYNC_STAGES];

    // Store the count on a detected edge while capture is enabled.
    always_ff @(posedge clk) begin
        if (!rst_n)         cap_q <= '0;
        else if (cap_event) cap_q <= count;
    end

    assign cap_val = cap_q;

endmodule

// File: rtl/multimode_timer.sv
// Module: top of the multi-mode 8/16-bit timer. Holds the control byte, the
// compare register and the three sticky flags, and joins prescaler, counter and capture.
// Assumes the processor strobes are single-cycle and synchronous to clk.
module multimode_timer
    import tmr_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_in,
    input  logic              cpu_cnt_we,
    input  logic [CNT_W-1:0]  cpu_cnt_wdata,
    input  logic              cpu_cmp_we,
    input  logic [CNT_W-1:0]  cpu_cmp_wdata,
    input  logic              cpu_ctrl_we,
    input  logic [CTRL_W-1:0] cpu_ctrl_wdata,
    input  logic [NUM_FLAGS-1:0] cpu_flag_clr,
    input  logic              irq_ack,
    output logic [CNT_W-1:0]  count,
    output logic              ovf_flag,
    output logic              cmp_flag,
    output logic [CNT_W-1:0]  cap_val,
    output logic              cap_flag,
    output logic              irq
);

    logic [CTRL_W-1:0]    ctrl_q;
    logic [CNT_W-1:0]     cmp_q;
    logic [NUM_FLAGS-1:0] flag_q;
    logic [NUM_FLAGS-1:0] flag_set;
    logic [NUM_FLAGS-1:0] flag_clr;
    logic [NUM_FLAGS-1:0] ien;
    logic [1:0]           clk_sel;
    tmr_mode_e            mode;
    logic                 tick;
    logic                 ev_ovf;
    logic                 ev_cmp;
    logic                 ev_cap;
    logic                 cap_mode;

    assign mode     = decode_mode(ctrl_q[CB_CAPEN], ctrl_q[CB_WIDE], ctrl_q[CB_CTC]);
    assign clk_sel  = ctrl_q[CB_SEL_LO +: 2];
    assign ien      = ctrl_q[CB_IEN_LO +: NUM_FLAGS];
    assign cap_mode = (mode == MD_CAP8) || (mode == MD_CAP16);

    // Control byte register.
    always_ff @(posedge clk) begin
        if (!rst_n)           ctrl_q <= '0;
        else if (cpu_ctrl_we) ctrl_q <= cpu_ctrl_wdata;
    end

    // Compare register, written straight through with no shadow copy.
    always_ff @(posedge clk) begin
        if (!rst_n)          cmp_q <= '0;
        else if (cpu_cmp_we) cmp_q <= cpu_cmp_wdata;
    end

    tmr_prescale u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .sel   (clk_sel),
        .tick  (tick)
    );

    tmr_count_core #(.CNT_W(CNT_W)) u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .mode    (mode),
        .cmp_val (cmp_q),
        .ld_en   (cpu_cnt_we),
        .ld_val  (cpu_cnt_wdata),
        .count   (count),
        .ev_ovf  (ev_ovf),
        .ev_cmp  (ev_cmp)
    );

    tmr_capture #(.CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES)) u_cap (
        .clk       (clk),
        .rst_n     (rst_n),
        .cap_in    (cap_in),
        .enable    (cap_mode),
        .count     (count),
        .cap_val   (cap_val),
        .cap_event (ev_cap)
    );

    // Gather the flag set and clear vectors; acknowledge also clears overflow.
    always_comb begin
        flag_set = {ev_cap, ev_cmp, ev_ovf};
        flag_clr = cpu_flag_clr | {{(NUM_FLAGS-1){1'b0}}, irq_ack};
    end

    // Sticky flags, a set in the same cycle outranks a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) flag_q <= '0;
        else        flag_q <= flag_set | (flag_q & ~flag_clr);
    end

    assign ovf_flag = flag_q[0];
    assign cmp_flag = flag_q[1];
    assign cap_flag = flag_q[2];
    assign irq      = |(flag_q & ien);

endmodule

// File: rtl/tmr_checker.sv
// Module: assertion checker bound to the timer top; observes ports and a few internals.
// Assumes the default 16-bit count width of the top module.
module tmr_checker
    import tmr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cpu_cnt_we,
    input logic [CNT_W-1:0] cpu_cnt_wdata,
    input logic [2:0]       cpu_flag_clr,
    input logic             irq_ack,
    input logic [CNT_W-1:0] count,
    input logic             ovf_flag,
    input logic             cmp_flag,
    input logic             cap_flag,
    input logic [CNT_W-1:0] cap_val,
    input logic             irq,
    input logic             tick,
    input tmr_mode_e        mode,
    input logic [CNT_W-1:0] cmp_q,
    input logic [1:0]       clk_sel
);

    localparam int HALF_W = CNT_W / 2;

    AST_CNT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_cnt_we |=> count == $past(cpu_cnt_wdata)); // R9

    AST_STOP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_sel == 2'd0 && !cpu_cnt_we) |=> $stable(count)); // R2

    AST_CTC_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MD_CTC8 && tick && !cpu_cnt_we && count[HALF_W-1:0] == cmp_q[HALF_W-1:0])
        |=> count[HALF_W-1:0] == '0); // R4

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_flag && !cpu_flag_clr[0] && !irq_ack) |=> ovf_flag); // R6

    AST_CMP_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_flag && !cpu_flag_clr[1]) |=> cmp_flag); // R8

    AST_CAP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !(mode == MD_CAP8 || mode == MD_CAP16) |=> $stable(cap_val)); // R11

    AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !(ovf_flag || cmp_flag || cap_flag) |-> !irq); // R12

endmodule

bind multimode_timer tmr_checker u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cpu_cnt_we    (cpu_cnt_we),
    .cpu_cnt_wdata (cpu_cnt_wdata),
    .cpu_flag_clr  (cpu_flag_clr),
    .irq_ack       (irq_ack),
    .count         (count),
    .ovf_flag      (ovf_flag),
    .cmp_flag      (cmp_flag),
    .cap_flag      (cap_flag),
    .cap_val       (cap_val),
    .irq           (irq),
    .tick          (tick),
    .mode          (mode),
    .cmp_q         (cmp_q),
    .clk_sel       (clk_sel)
);

// File: tb/multimode_timer_tb.sv
module multimode_timer_tb;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cap_in = 1'b0;
    logic        cnt_we = 1'b0;
    logic [15:0] cnt_wd = '0;
    logic        cmp_we = 1'b0;
    logic [15:0] cmp_wd = '0;
    logic        ctrl_we = 1'b0;
    logic [7:0]  ctrl_wd = '0;
    logic [2:0]  fclr = '0;
    logic        ack = 1'b0;

    logic [15:0] count;
    logic        ovf_flag;
    logic        cmp_flag;
    logic [15:0] cap_val;
    logic        cap_flag;
    logic        irq;

    int total = 0;
    int bad = 0;

    // Bench model state, built from the requirements.
    logic [15:0] m_cnt = '0;
    logic [15:0] m_cmp = '0;
    logic [7:0]  m_ctrl = '0;
    logic [2:0]  m_flag = '0;
    logic [15:0] m_cap = '0;
    logic [5:0]  m_pre = '0;
    logic [2:0]  m_sync = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    multimode_timer u_dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .cap_in         (cap_in),
        .cpu_cnt_we     (cnt_we),
        .cpu_cnt_wdata  (cnt_wd),
        .cpu_cmp_we     (cmp_we),
        .cpu_cmp_wdata  (cmp_wd),
        .cpu_ctrl_we    (ctrl_we),
        .cpu_ctrl_wdata (ctrl_wd),
        .cpu_flag_clr   (fclr),
        .irq_ack        (ack),
        .count          (count),
        .ovf_flag       (ovf_flag),
        .cmp_flag       (cmp_flag),
        .cap_val        (cap_val),
        .cap_flag       (cap_flag),
        .irq            (irq)
    );

    task automatic chk(input string what, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", what, act, exp);
        end
    endtask

    // R2: tick for a select code and prescaler phase.
    function automatic logic exp_tick(input logic [1:0] sel, input logic [5:0] pre);
        case (sel)
            2'd0:    return 1'b0;
            2'd1:    return 1'b1;
            2'd2:    return pre[2:0] == 3'd7;
            default: return pre == 6'd63;
        endcase
    endfunction

    function automatic logic is_wide(input logic [7:0] c);
        return c[1] | c[2] ? c[1] : 1'b0;
    endfunction

    function automatic logic is_ctc(input logic [7:0] c);
        return c[0] & ~c[1] & ~c[2];
    endfunction

    // R3 R4 R5: next count for one tick.
    function automatic logic [15:0] exp_next(input logic [15:0] c, input logic [15:0] cp, input logic [7:0] ctl);
        if (is_wide(ctl)) return c + 16'd1;
        if (is_ctc(ctl) && c[7:0] == cp[7:0]) return {c[15:8], 8'h00};
        return {c[15:8], c[7:0] + 8'd1};
    endfunction

    task automatic model_edge();
        logic tk, w, hit, eo, ec, ecap;
        tk   = exp_tick(m_ctrl[4:3], m_pre);
        w    = is_wide(m_ctrl);
        hit  = w ? (m_cnt == m_cmp) : (m_cnt[7:0] == m_cmp[7:0]);
        eo   = tk && !cnt_we && (w ? (m_cnt == 16'hFFFF) : (m_cnt[7:0] == 8'hFF));
        ec   = tk && !cnt_we && hit;
        ecap = m_ctrl[2] && m_sync[1] && !m_sync[2];
        if (ecap) m_cap = m_cnt;
        m_flag[0] = eo   | (m_flag[0] & ~fclr[0] & ~ack);
        m_flag[1] = ec   | (m_flag[1] & ~fclr[1]);
        m_flag[2] = ecap | (m_flag[2] & ~fclr[2]);
        if (cnt_we)  m_cnt = cnt_wd;
        else if (tk) m_cnt = exp_next(m_cnt, m_cmp, m_ctrl);
        if (cmp_we)  m_cmp = cmp_wd;
        if (ctrl_we) m_ctrl = ctrl_wd;
        m_sync = {m_sync[1:0], cap_in};
        m_pre  = m_pre + 6'd1;
    endtask

    task automatic compare_all();
        chk("R3/R4/R5 count", count, m_cnt);
        chk("R6 ovf_flag", {15'd0, ovf_flag}, {15'd0, m_flag[0]});
        chk("R8 cmp_flag", {15'd0, cmp_flag}, {15'd0, m_flag[1]});
        chk("R11 cap_val", cap_val, m_cap);
        chk("R11 cap_flag", {15'd0, cap_flag}, {15'd0, m_flag[2]});
        chk("R12 irq", {15'd0, irq}, {15'd0, |(m_flag & m_ctrl[7:5])});
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            model_edge();
            @(negedge clk);
            compare_all();
            cnt_we = 1'b0; cmp_we = 1'b0; ctrl_we = 1'b0; fclr = '0; ack = 1'b0;
        end
    endtask

    task automatic wr_ctrl(input logic [7:0] v); ctrl_we = 1'b1; ctrl_wd = v; endtask
    task automatic wr_cnt(input logic [15:0] v); cnt_we = 1'b1; cnt_wd = v; endtask
    task automatic wr_cmp(input logic [15:0] v); cmp_we = 1'b1; cmp_wd = v; endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired act=%0d exp=%0d", 1, 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [15:0] base;
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 count", count, 16'h0000);
        chk("R1 flags", {13'd0, cap_flag, cmp_flag, ovf_flag}, 16'h0000);
        chk("R1 cap_val", cap_val, 16'h0000);
        chk("R1 irq", {15'd0, irq}, 16'h0000);
        rst_n = 1'b1;

        // R2 stopped: select 0 holds the count
        run(20);
        chk("R2 stopped count", count, 16'h0000);

        // R3 R13 normal 8-bit, high byte held, R6 overflow on FF->00
        wr_ctrl(8'h08); wr_cnt(16'h12FD); run(1);
        chk("R9 loaded count", count, 16'h12FD);
        run(3);
        chk("R3 wrap keeps high byte", count, 16'h1200);
        chk("R6 overflow set", {15'd0, ovf_flag}, 16'd1);

        // R7 clear by acknowledge, then set wins over clear
        ack = 1'b1; run(1);
        chk("R7 ack clears", {15'd0, ovf_flag}, 16'd0);
        wr_cnt(16'h00FE); run(1); run(1);
        chk("R7 at FF", count, 16'h00FF);
        fclr = 3'b001; run(1);
        chk("R7 set wins", {15'd0, ovf_flag}, 16'd1);
        fclr = 3'b001; run(1);
        chk("R7 clear", {15'd0, ovf_flag}, 16'd0);

        // R4 clear-on-compare sequence with compare 5, R8 flag
        wr_ctrl(8'h09); wr_cmp(16'h0005); wr_cnt(16'h0000); fclr = 3'b111; run(1);
        run(5);
        chk("R4 reached compare", count, 16'h0005);
        chk("R8 not yet", {15'd0, cmp_flag}, 16'd0);
        run(1);
        chk("R4 cleared", count, 16'h0000);
        chk("R8 match flag", {15'd0, cmp_flag}, 16'd1);

        // R10 compare write takes effect next edge
        run(1);
        wr_cmp(16'h0003); run(1);
        chk("R10 count 2", count, 16'h0002);
        run(2);
        chk("R10 new compare clears", count, 16'h0000);

        // R9 write on a compare hit overrides the clear and suppresses the flag
        fclr = 3'b010; run(3);
        chk("R9 at compare", count, 16'h0003);
        wr_cnt(16'h0040); run(1);
        chk("R9 write wins", count, 16'h0040);
        chk("R9 no event", {15'd0, cmp_flag}, 16'd0);

        // R13 wide plus ctc bit: clear ignored
        wr_ctrl(8'h0B); wr_cmp(16'h0005); wr_cnt(16'h0004); run(1);
        run(3);
        chk("R13 ctc ignored in wide", count, 16'h0007);

        // R5 16-bit wrap
        wr_ctrl(8'h0A); wr_cnt(16'hFFFE); fclr = 3'b111; run(1);
        run(2);
        chk("R5 16-bit wrap", count, 16'h0000);
        chk("R6 16-bit overflow", {15'd0, ovf_flag}, 16'd1);

        // R12 enable routes overflow to irq
        wr_ctrl(8'h2A); run(1);
        chk("R12 irq enabled", {15'd0, irq}, 16'd1);
        wr_ctrl(8'h4A); run(1);
        chk("R12 irq masked", {15'd0, irq}, 16'd0);

        // R2 divide by 8 and by 64
        wr_ctrl(8'h10); wr_cnt(16'h0000); run(1);
        run(64);
        chk("R2 div8 window", count, 16'h0008);
        wr_ctrl(8'h18); wr_cnt(16'h0000); run(1);
        run(128);
        chk("R2 div64 window", count, 16'h0002);

        // R11 capture in 8-bit capture mode
        wr_ctrl(8'h0C); wr_cnt(16'h0010); fclr = 3'b111; run(1);
        cap_in = 1'b1; run(3);
        chk("R11 captured value", cap_val, 16'h0012);
        chk("R11 capture flag", {15'd0, cap_flag}, 16'd1);
        cap_in = 1'b0; run(4);

        // R11 capture ignored outside capture modes
        wr_ctrl(8'h08); fclr = 3'b100; run(1);
        base = cap_val;
        cap_in = 1'b1; run(5);
        chk("R11 ignored value", cap_val, base);
        chk("R11 ignored flag", {15'd0, cap_flag}, 16'd0);
        cap_in = 1'b0; run(2);

        // Constrained random mix
        for (int i = 0; i < 4000; i++) begin
            if ($urandom % 200 == 0) wr_ctrl(8'($urandom));
            if ($urandom % 40 == 0)  wr_cnt(16'($urandom));
            if ($urandom % 50 == 0)  wr_cmp(($urandom % 2 == 0) ? 16'($urandom % 32) : 16'($urandom));
            if ($urandom % 25 == 0)  fclr = 3'($urandom);
            if ($urandom % 30 == 0)  ack = 1'b1;
            if ($urandom % 9 == 0)   cap_in = ~cap_in;
            if (i % 500 == 0)        wr_ctrl({3'($urandom), 2'd1, 3'($urandom)});
            run(1);
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule